// File: doc/BRIEF.md
# MDIO Management Command Engine

This block lets software on a 10/100 Ethernet MAC reach the registers of an external PHY over the two-wire management bus. Software sees two 16-bit internal registers. One holds data and the other holds a packed command. A write to the command register starts one clause-22 frame. The engine then shifts the frame out on the management data line, timed by a management clock that it derives from the system clock.

On a read frame the engine releases the data line partway through the turnaround. It then shifts in the sixteen bits the PHY returns and places them in the data register. On a write frame it sends the data register contents as they stood when the command was accepted. The only handshake is a finished flag in the command register, which software polls. Because a bus with no PHY attached floats high, a read from an empty address returns all ones.

Top module: `mdio_cmd_engine`

## Requirements
- R1: Register select `reg_addr`=1 addresses the command register and 0 addresses the data register. In the command word, bit 13 is the operation (1 write, 0 read), bits 12:8 are the PHY address and bits 4:0 are the register number. Reading the command register returns the accepted fields in those positions, the finished flag in bit 15, and zeros in bits 14 and 7:5.
- R2: The finished flag is 1 when idle. After a command is accepted it is 0 for exactly 128*H system cycles and then returns to 1, where H = ceil(CLK_HZ / (2*MDC_MAX_HZ)).
- R3: Each frame holds 64 bits, first bit first: 32 ones, then 01, then an opcode of 01 for write or 10 for read, then the PHY address MSB first, then the register number MSB first, then two turnaround bits (10 on a write), then 16 data bits MSB first.
- R4: A write frame carries the data register value held at the cycle the command was accepted. Data register writes made during the frame do not alter the bits sent.
- R5: On a read frame the output enable is high for bits 0 to 46, with bit 46 driven as 1, and low from bit 47 to the end. The input is sampled on the rising management clock edge of bits 48 to 63, MSB first. The 16-bit result is readable from the data register once the finished flag is back at 1.
- R6: A read that no PHY answers (input held high) returns 0xFFFF.
- R7: The management clock is low whenever the engine is idle. Each frame bit is a low half then a high half, each exactly H system cycles, so the clock stays high for 64*H cycles per frame.
- R8: A command-register write that arrives while a frame is in progress is ignored. It starts no frame and leaves the command fields unchanged.
- R9: After reset the finished flag is 1, the management clock is 0, the output enable is 0 and the data register is 0.
- R10: The data output and output enable change only when the management clock falls or a frame starts. They hold steady while the clock is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 1 command, 0 data |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the selected register (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data output value |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data input from the pad |

## Verification
The finished flag drops on the first system cycle after the command write is sampled. It rises again 128*H cycles later. The bench counts falling system-clock edges from that point and compares the total with the figure given in R2. The data register is updated on the same edge that restores the finished flag, so the bench reads the result on the first falling edge at which it sees the flag set. Frame bits are sampled one nanosecond after each rising management clock edge, and the bench PHY model drives its reply one nanosecond after each falling edge. Each value is therefore stable for H system cycles before the engine samples it.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   typedef enum logic {
      OP_READ  = 1'b0,
      OP_WRITE = 1'b1
   } mdio_op_e;

   typedef struct packed {
      mdio_op_e   op;
      logic [4:0] phy;
      logic [4:0] regn;
   } mdio_cmd_t;

   localparam int FRAME_BITS    = 64;
   localparam int RELEASE_BIT   = 47;
   localparam int DATA_FIRST    = 48;
endpackage

// File: rtl/mdc_divider.sv
module mdc_divider #(
   parameter int HALF = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise_en,
   output logic fall_en
);
   localparam int CW = (HALF > 2) ? $clog2(HALF) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF - 1);

   logic [CW-1:0] cnt;
   logic          wrap;

   generate
      if (HALF < 2) begin : g_bad_half
         $error("mdc_divider: HALF must be at least 2");
      end
   endgenerate

   assign wrap    = run && (cnt == LAST);
   assign rise_en = wrap && !mdc;
   assign fall_en = wrap && mdc;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (wrap) begin
         cnt <= '0;
         mdc <= ~mdc;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
   import mdio_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  mdio_cmd_t   cmd,
   input  logic [15:0] wdata,
   input  logic        rise_en,
   input  logic        fall_en,
   input  logic        mdio_i,
   output logic        busy,
   output logic        mdio_o,
   output logic        mdio_oe,
   output logic        rd_done,
   output logic [15:0] rd_value
);
   localparam logic [5:0] LAST_BIT = 6'(FRAME_BITS - 1);
   localparam logic [5:0] REL_BIT  = 6'(RELEASE_BIT);
   localparam logic [5:0] DAT_BIT  = 6'(DATA_FIRST);

   logic [FRAME_BITS-1:0] shift_q;
   logic [5:0]            bit_idx;
   logic                  is_read;
   logic [15:0]           cap_q;
   logic                  is_wr;

   assign is_wr = (cmd.op == OP_WRITE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shift_q <= '1;
         bit_idx <= '0;
         is_read <= 1'b0;
         busy    <= 1'b0;
         cap_q   <= '0;
      end else if (start) begin
         shift_q <= {32'hFFFF_FFFF, 2'b01,
                     is_wr ? 2'b01 : 2'b10,
                     cmd.phy, cmd.regn,
                     is_wr ? 2'b10 : 2'b11,
                     is_wr ? wdata : 16'hFFFF};
         bit_idx <= '0;
         is_read <= !is_wr;
         busy    <= 1'b1;
      end else if (busy) begin
         if (rise_en && is_read && (bit_idx >= DAT_BIT))
            cap_q <= {cap_q[14:0], mdio_i};
         if (fall_en) begin
            if (bit_idx == LAST_BIT) begin
               busy <= 1'b0;
            end else begin
               bit_idx <= bit_idx + 1'b1;
               shift_q <= {shift_q[FRAME_BITS-2:0], 1'b1};
            end
         end
      end
   end

   assign mdio_o   = busy ? shift_q[FRAME_BITS-1] : 1'b1;
   assign mdio_oe  = busy && !(is_read && (bit_idx >= REL_BIT));
   assign rd_done  = busy && fall_en && is_read && (bit_idx == LAST_BIT);
   assign rd_value = cap_q;
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
   import mdio_pkg::*;
#(
   parameter int CLK_HZ     = 100_000_000,
   parameter int MDC_MAX_HZ = 2_500_000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic        reg_addr,
   input  logic [15:0] reg_wdata,
   output logic [15:0] reg_rdata,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i
);
   localparam int HALF_CYC = (CLK_HZ + 2 * MDC_MAX_HZ - 1) / (2 * MDC_MAX_HZ);

   generate
      if (MDC_MAX_HZ <= 0 || CLK_HZ <= 0) begin : g_bad_freq
         $error("mdio_cmd_engine: clock rates must be positive");
      end
   endgenerate

   mdio_cmd_t   cmd_q;
   mdio_cmd_t   cmd_new;
   logic [15:0] data_q;
   logic [15:0] ctl_view;
   logic [15:0] rd_value;
   logic        busy;
   logic        start;
   logic        rise_en;
   logic        fall_en;
   logic        rd_done;
   logic        unused_ctl_bits;

   assign unused_ctl_bits = ^{reg_wdata[15:14], reg_wdata[7:5]};

   assign cmd_new = '{op: mdio_op_e'(reg_wdata[13]),
                      phy: reg_wdata[12:8],
                      regn: reg_wdata[4:0]};
   assign start = reg_wr && reg_addr && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q  <= '0;
         data_q <= '0;
      end else begin
         if (start)
            cmd_q <= cmd_new;
         if (rd_done)
            data_q <= rd_value;
         else if (reg_wr && !reg_addr)
            data_q <= reg_wdata;
      end
   end

   assign ctl_view  = {!busy, 1'b0, cmd_q.op, cmd_q.phy, 3'b000, cmd_q.regn};
   assign reg_rdata = reg_addr ? ctl_view : data_q;

   mdc_divider #(.HALF(HALF_CYC)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (busy),
      .mdc     (mdc),
      .rise_en (rise_en),
      .fall_en (fall_en)
   );

   mdio_frame_engine u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .cmd      (cmd_new),
      .wdata    (data_q),
      .rise_en  (rise_en),
      .fall_en  (fall_en),
      .mdio_i   (mdio_i),
      .busy     (busy),
      .mdio_o   (mdio_o),
      .mdio_oe  (mdio_oe),
      .rd_done  (rd_done),
      .rd_value (rd_value)
   );
endmodule

// File: rtl/mdio_cmd_engine_chk.sv
module mdio_cmd_engine_chk #(
   parameter int HALF = 20
) (
   input logic        clk,
   input logic        rst_n,
   input logic        reg_wr,
   input logic        reg_addr,
   input logic        busy,
   input logic [15:0] ctl_word,
   input logic        mdc,
   input logic        mdio_o,
   input logic        mdio_oe
);
   localparam int RW = $clog2(HALF + 1) + 2;

   logic          mdc_d;
   logic [RW-1:0] run_len;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mdc_d   <= 1'b0;
         run_len <= '0;
      end else begin
         mdc_d   <= mdc;
         run_len <= (mdc != mdc_d) ? RW'(1) : run_len + 1'b1;
      end
   end

   // R2
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr && !busy) |=> busy);

   // R8
   ignore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr && busy) |=> $stable(ctl_word[13:0]));

   // R7
   idle_mdc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdc);

   // R7
   mdc_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mdc_d && !mdc) |-> (run_len == RW'(HALF)));

   // R5
   idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdio_oe);

   // R10
   stable_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));
endmodule

bind mdio_cmd_engine mdio_cmd_engine_chk #(.HALF(HALF_CYC)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_wr   (reg_wr),
   .reg_addr (reg_addr),
   .busy     (busy),
   .ctl_word (ctl_view),
   .mdc      (mdc),
   .mdio_o   (mdio_o),
   .mdio_oe  (mdio_oe)
);

// File: tb/mdio_cmd_engine_test.sv
`timescale 1ns/1ps
module mdio_cmd_engine_test;
   localparam int HALF_EXP = 5;          // ceil(250e6 / (2*25e6))
   localparam logic [4:0] PHY_ADDR = 5'd5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_addr = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b1;

   int checks = 0;
   int fails  = 0;
   logic [15:0]  phy_val = '0;
   logic [127:0] exp_q[$];

   always #2 clk = ~clk;

   mdio_cmd_engine #(.CLK_HZ(250_000_000), .MDC_MAX_HZ(25_000_000)) uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got %h exp %h", req, got, exp);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   endtask

   task automatic rd(input logic a, output logic [15:0] v);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   function automatic logic [127:0] frame_exp(input bit wr, input logic [4:0] pa,
                                              input logic [4:0] ra, input logic [15:0] wd);
      logic [63:0] b, oe;
      b  = {32'hFFFF_FFFF, 2'b01, wr ? 2'b01 : 2'b10, pa, ra,
            wr ? 2'b10 : 2'b11, wr ? wd : 16'hFFFF};
      oe = wr ? {64{1'b1}} : {{47{1'b1}}, 17'b0};
      return {b, oe};
   endfunction

   // Monitor and PHY model: collects each frame, answers reads at PHY_ADDR
   initial begin
      forever begin
         logic [63:0] gb, go, eb, eo;
         logic [127:0] e;
         bit respond;
         @(negedge uut.u_frame.busy or negedge reg_rdata[15]);
         respond = 1'b0;
         gb = '0; go = '0;
         wait (mdc == 1'b0);
         for (int k = 0; k < 64; k++) begin
            @(posedge mdc);
            #1;
            gb[63-k] = mdio_o;
            go[63-k] = mdio_oe;
            if (k == 45)
               respond = (gb[63-34] == 1'b1) && (gb[63-35] == 1'b0) &&
                         (gb[63-36 -: 5] == PHY_ADDR);
            @(negedge mdc);
            #1;
            if (respond && (k + 1 == 47))
               mdio_i = 1'b0;
            else if (respond && (k + 1 >= 48) && (k + 1 <= 63))
               mdio_i = phy_val[63 - (k + 1)];
            else
               mdio_i = 1'b1;
         end
         if (exp_q.size() == 0) begin
            chk("R8 unexpected frame", 64'd1, 64'd0);
         end else begin
            e = exp_q.pop_front();
            eb = e[127:64];
            eo = e[63:0];
            chk("R3/R4 frame bits", gb & eo, eb & eo);
            chk("R5 output enable", go, eo);
         end
      end
   end

   task automatic run_cmd(input bit wr, input logic [4:0] pa, input logic [4:0] ra,
                          input logic [15:0] wd, input bit inject);
      int cnt, hi;
      logic [15:0] v, exp_data;
      if (wr) begin
         @(negedge clk);
         reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = wd;
      end
      exp_q.push_back(frame_exp(wr, pa, ra, wd));
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = {2'b00, wr, pa, 3'b000, ra};
      @(negedge clk);
      reg_wr = 1'b0;
      rd(1'b1, v);
      chk("R2 flag clear after accept", 64'(v[15]), 64'd0);
      cnt = 0; hi = 0;
      while (v[15] == 1'b0) begin
         if (mdc) hi++;
         cnt++;
         if (inject && cnt == 100) begin
            reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 16'h1234;   // R4
         end else if (inject && cnt == 200) begin
            reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = {3'b000, 5'd9, 3'b000, 5'd1}; // R8
         end else begin
            reg_wr = 1'b0;
         end
         @(negedge clk);
         reg_wr = 1'b0;
         rd(1'b1, v);
      end
      chk("R2 busy length", 64'(cnt), 64'(128 * HALF_EXP));
      chk("R7 mdc high cycles", 64'(hi), 64'(64 * HALF_EXP));
      chk("R1 command readback", 64'(v), 64'({1'b1, 1'b0, wr, pa, 3'b000, ra}));
      if (wr) exp_data = inject ? 16'h1234 : wd;
      else    exp_data = (pa == PHY_ADDR) ? phy_val : 16'hFFFF;
      rd(1'b0, v);
      if (wr)                 chk("R4 data register", 64'(v), 64'(exp_data));
      else if (pa == PHY_ADDR) chk("R5 read result", 64'(v), 64'(exp_data));
      else                    chk("R6 absent PHY", 64'(v), 64'(exp_data));
   endtask

   initial begin
      logic [15:0] v;
      bit stayed;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      rd(1'b1, v);
      chk("R9 flag after reset", 64'(v[15]), 64'd1);
      chk("R9 mdc after reset", 64'(mdc), 64'd0);
      chk("R9 oe after reset", 64'(mdio_oe), 64'd0);
      rd(1'b0, v);
      chk("R9 data after reset", 64'(v), 64'd0);

      run_cmd(1'b1, 5'd5, 5'd3, 16'hA5C3, 1'b1);
      stayed = 1'b1;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         rd(1'b1, v);
         if (v[15] !== 1'b1 || mdc !== 1'b0) stayed = 1'b0;
      end
      chk("R8 no frame after ignored write", 64'(stayed), 64'd1);

      phy_val = 16'h1D4E;
      run_cmd(1'b0, 5'd5, 5'd2, 16'h0000, 1'b0);
      run_cmd(1'b0, 5'd9, 5'd1, 16'h0000, 1'b0);
      run_cmd(1'b1, 5'd31, 5'd31, 16'h0000, 1'b0);
      phy_val = 16'h8001;
      run_cmd(1'b0, 5'd5, 5'd31, 16'h0000, 1'b0);
      run_cmd(1'b0, 5'd0, 5'd17, 16'h0000, 1'b0);
      repeat (10) @(negedge clk);
      chk("R3 all frames seen", 64'(exp_q.size()), 64'd0);
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end
endmodule